// File: doc/BRIEF.md
# Regularly Sampled Triangular PWM Modulator

This block turns a continuous duty command into a two-level switching state for one inverter leg. An up/down counter forms a symmetric triangular carrier that climbs from zero to a programmable peak and falls back. Each turning point of the carrier marks the start of a half period. At each one the block raises a sample strobe, so a regularly sampled current controller runs exactly twice per carrier period.

The duty command always refers to the state applied first in a half period. A half period that starts at the carrier top applies +1 first and then -1. A half period that starts at the bottom applies -1 first and then +1. On rising halves the block therefore commands the complement of the duty for the +1 state. The block also reports which state comes first and which comes second in the current half, so the controller can pick its slopes.

A duty written between two turning points is held and only takes effect when the next half period begins. The active duty is scaled to a whole-count threshold once per half. The switching state is a registered compare of the position inside the half against that threshold.

Top module: `pwm_tri_mod`

## Requirements
- R1: The carrier count steps by one per clock from 0 up to the peak and back down to 0, visiting each turning value for exactly one clock, so a full period lasts 2*peak clocks; `strobe` is high exactly in the clocks where the count sits at 0 or at the peak.
- R2: `carrier_up` is high from the clock at the bottom turning point up to and including the clock before the top turning point, and low for the rest of the period.
- R3: `peak_cfg` is taken only at the clock edge that brings the carrier back to 0; a value of 0 is treated as 1.
- R4: `duty_in` is unsigned with DUTY_W fraction bits, where 2^DUTY_W means 1.0; codes above 2^DUTY_W are treated as 1.0. The threshold of a half period is duty*peak/2^DUTY_W rounded to the nearest count, with ties rounded up.
- R5: A duty sampled with `duty_vld` at a clock edge replaces the held duty. It first takes effect for the half period that begins at the next edge entering a turning point, including that same edge, and it leaves the half period in progress unchanged.
- R6: In a half period that starts at the top turning point, `sw_pos` is 1 (state +1) for the first threshold clocks and 0 (state -1) for the rest.
- R7: In a half period that starts at the bottom turning point, `sw_pos` is 0 for the first threshold clocks and 1 for the rest, so the +1 state receives the complementary duty.
- R8: A duty of 0 or of 1.0 produces no change of `sw_pos` inside a half period.
- R9: `s1_pos` is 1 in half periods that start at the top and 0 in those that start at the bottom; `s2_pos` is always its complement.
- R10: With a duty of exactly one half and an even peak, a full carrier period holds equal numbers of +1 and -1 clocks.
- R11: While reset is high the carrier sits at 0 counting up with peak RST_PEAK, the held duty is one half, and `sw_pos` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| duty_in | input | DUTY_W+1 | Duty command for the first applied state, 2^DUTY_W = 1.0 |
| duty_vld | input | 1 | Qualifies `duty_in` for one clock |
| peak_cfg | input | CNT_W | Carrier peak count, taken at the bottom turning point |
| sw_pos | output | 1 | Switching state, 1 = +1, 0 = -1 |
| strobe | output | 1 | High in clocks at a carrier turning point |
| carrier_up | output | 1 | High while the carrier is rising |
| s1_pos | output | 1 | First applied state of the current half, 1 = +1 |
| s2_pos | output | 1 | Second applied state of the current half, 1 = +1 |

## Verification
The bench builds the block with an 8-bit carrier, six duty fraction bits and a reset peak of 10. Whole periods are then only a few tens of clocks, so hundreds of half periods, peak changes and mid-half duty writes fit in a short run. The 7-bit duty input can carry codes above 1.0 to exercise the clamp. Small and odd peaks make the rounding ties, the zero-peak clamp and the single-clock half periods reachable.

// File: rtl/pwm_tri_pkg.sv
package pwm_tri_pkg;

  // Which turning point opened the current half period
  typedef enum logic {
    HALF_RISE = 1'b0,
    HALF_FALL = 1'b1
  } half_e;

  // Limit a duty code to full scale (2^dw)
  function automatic logic [31:0] clamp_duty(input logic [31:0] d, input int dw);
    logic [31:0] full;
    full = 32'd1 << dw;
    return (d > full) ? full : d;
  endfunction

  // A zero peak would stall the carrier; use one count instead
  function automatic logic [31:0] clamp_peak(input logic [31:0] p);
    return (p == 32'd0) ? 32'd1 : p;
  endfunction

  // Threshold = round(d * p / 2^dw), ties upward
  function automatic logic [31:0] duty_to_thr(input logic [31:0] d, input logic [31:0] p,
                                              input int dw);
    logic [63:0] prod;
    prod = ({32'd0, d} * {32'd0, p}) + (64'd1 << (dw - 1));
    prod = prod >> dw;
    return prod[31:0];
  endfunction

  // Output level for a position inside a half period
  function automatic logic level_pos(input half_e h, input logic [31:0] idx,
                                     input logic [31:0] thr);
    if (h == HALF_FALL) return idx < thr;
    return idx >= thr;
  endfunction

endpackage

// File: rtl/pwm_tri_carrier.sv
module pwm_tri_carrier #(
  parameter int CNT_W    = 12,
  parameter int RST_PEAK = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] peak_cfg,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] peak_q,
  output logic             rise_q,
  output logic [CNT_W-1:0] cnt_d,
  output logic [CNT_W-1:0] peak_d,
  output logic             rise_d,
  output logic             ext_d
);
  import pwm_tri_pkg::*;

  localparam logic [CNT_W-1:0] PEAK_RST = CNT_W'(clamp_peak(32'(RST_PEAK)));

  always_comb begin
    peak_d = peak_q;
    rise_d = rise_q;
    if (rise_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_d == peak_q) rise_d = 1'b0;
    end else begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_d == '0) begin
        rise_d = 1'b1;
        peak_d = CNT_W'(clamp_peak(32'(peak_cfg)));
      end
    end
    ext_d = (cnt_d == '0) || (cnt_d == peak_d);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      peak_q <= PEAK_RST;
      rise_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      peak_q <= peak_d;
      rise_q <= rise_d;
    end
  end

endmodule

// File: rtl/pwm_tri_duty.sv
module pwm_tri_duty #(
  parameter int CNT_W    = 12,
  parameter int DUTY_W   = 10,
  parameter int RST_PEAK = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DUTY_W:0]  duty_in,
  input  logic             duty_vld,
  input  logic             ext_d,
  input  logic [CNT_W-1:0] peak_d,
  output logic [CNT_W-1:0] thr_new,
  output logic [CNT_W-1:0] thr_q
);
  import pwm_tri_pkg::*;

  localparam logic [DUTY_W:0]  DUTY_HALF = (DUTY_W+1)'(1) << (DUTY_W - 1);
  localparam logic [CNT_W-1:0] THR_RST   =
    CNT_W'(duty_to_thr(32'(DUTY_HALF), clamp_peak(32'(RST_PEAK)), DUTY_W));

  logic [DUTY_W:0] pend_q;
  logic [DUTY_W:0] duty_eff;
  logic [DUTY_W:0] duty_lim;

  always_comb begin
    duty_eff = duty_vld ? duty_in : pend_q;
    duty_lim = (DUTY_W+1)'(clamp_duty(32'(duty_eff), DUTY_W));
    thr_new  = CNT_W'(duty_to_thr(32'(duty_lim), 32'(peak_d), DUTY_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= DUTY_HALF;
      thr_q  <= THR_RST;
    end else begin
      if (duty_vld) pend_q <= duty_in;
      if (ext_d)    thr_q  <= thr_new;
    end
  end

endmodule

// File: rtl/pwm_tri_cmp.sv
module pwm_tri_cmp #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic [CNT_W-1:0] peak_d,
  input  logic             rise_d,
  input  logic             ext_d,
  input  logic [CNT_W-1:0] thr_sel,
  output logic             pos_q,
  output logic             first_pos_q
);
  import pwm_tri_pkg::*;

  half_e            half_w;
  logic [CNT_W-1:0] idx_w;
  logic             pos_d;

  always_comb begin
    half_w = rise_d ? HALF_RISE : HALF_FALL;
    idx_w  = rise_d ? cnt_d : (peak_d - cnt_d);
    pos_d  = level_pos(half_w, 32'(idx_w), 32'(thr_sel));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q       <= 1'b0;
      first_pos_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      if (ext_d) first_pos_q <= (cnt_d != '0);
    end
  end

endmodule

// File: rtl/pwm_tri_mod.sv
module pwm_tri_mod #(
  parameter int CNT_W    = 12,
  parameter int DUTY_W   = 10,
  parameter int RST_PEAK = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DUTY_W:0]  duty_in,
  input  logic             duty_vld,
  input  logic [CNT_W-1:0] peak_cfg,
  output logic             sw_pos,
  output logic             strobe,
  output logic             carrier_up,
  output logic             s1_pos,
  output logic             s2_pos
);

  logic [CNT_W-1:0] cnt_q, peak_q, cnt_d, peak_d;
  logic             rise_q, rise_d, ext_d;
  logic [CNT_W-1:0] thr_new, thr_q, thr_sel;
  logic             pos_q, first_pos_q;
  logic             at_extremum;

  pwm_tri_carrier #(.CNT_W(CNT_W), .RST_PEAK(RST_PEAK)) u_car (
    .clk(clk), .rst(rst), .peak_cfg(peak_cfg),
    .cnt_q(cnt_q), .peak_q(peak_q), .rise_q(rise_q),
    .cnt_d(cnt_d), .peak_d(peak_d), .rise_d(rise_d), .ext_d(ext_d)
  );

  pwm_tri_duty #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .RST_PEAK(RST_PEAK)) u_duty (
    .clk(clk), .rst(rst), .duty_in(duty_in), .duty_vld(duty_vld),
    .ext_d(ext_d), .peak_d(peak_d), .thr_new(thr_new), .thr_q(thr_q)
  );

  assign thr_sel = ext_d ? thr_new : thr_q;

  pwm_tri_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst(rst), .cnt_d(cnt_d), .peak_d(peak_d), .rise_d(rise_d),
    .ext_d(ext_d), .thr_sel(thr_sel), .pos_q(pos_q), .first_pos_q(first_pos_q)
  );

  assign at_extremum = (cnt_q == '0) || (cnt_q == peak_q);

  assign sw_pos     = pos_q;
  assign strobe     = at_extremum;
  assign carrier_up = rise_q;
  assign s1_pos     = first_pos_q;
  assign s2_pos     = ~first_pos_q;

endmodule

// File: rtl/pwm_tri_mod_chk.sv
module pwm_tri_mod_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             strobe,
  input logic             carrier_up,
  input logic             sw_pos,
  input logic             s1_pos,
  input logic             s2_pos,
  input logic [CNT_W-1:0] thr,
  input logic [CNT_W-1:0] peak
);

  assert_turn_single_clock_R1: assert property (@(posedge clk) disable iff (rst)
    (strobe && peak > 1) |=> !strobe);

  assert_dir_turns_at_extremum_R2: assert property (@(posedge clk) disable iff (rst)
    (carrier_up != $past(carrier_up)) |-> strobe);

  assert_thr_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    thr <= peak);

  assert_thr_held_mid_half_R5: assert property (@(posedge clk) disable iff (rst)
    !strobe |-> $stable(thr));

  assert_fall_single_edge_R6: assert property (@(posedge clk) disable iff (rst)
    (!carrier_up && !strobe && !$past(sw_pos)) |-> !sw_pos);

  assert_rise_single_edge_R7: assert property (@(posedge clk) disable iff (rst)
    (carrier_up && !strobe && $past(sw_pos)) |-> sw_pos);

  assert_flat_half_R8: assert property (@(posedge clk) disable iff (rst)
    ((thr == '0 || thr == peak) && !strobe) |-> $stable(sw_pos));

  assert_order_matches_dir_R9: assert property (@(posedge clk) disable iff (rst)
    (s1_pos != carrier_up) && (s2_pos != s1_pos));

endmodule

bind pwm_tri_mod pwm_tri_mod_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .carrier_up(carrier_up),
  .sw_pos(sw_pos), .s1_pos(s1_pos), .s2_pos(s2_pos),
  .thr(thr_q), .peak(peak_q)
);

// File: tb/sim_pwm_tri_mod.sv
module sim_pwm_tri_mod;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 8;
  localparam int DW   = 6;
  localparam int RP   = 10;
  localparam int FULL = 1 << DW;
  localparam int HALF = FULL / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW:0]   duty_in = '0;
  logic          duty_vld = 1'b0;
  logic [CW-1:0] peak_cfg = CW'(RP);
  logic          sw_pos, strobe, carrier_up, s1_pos, s2_pos;

  int checks = 0;
  int errors = 0;

  pwm_tri_mod #(.CNT_W(CW), .DUTY_W(DW), .RST_PEAK(RP)) u0 (
    .clk(clk), .rst(rst), .duty_in(duty_in), .duty_vld(duty_vld), .peak_cfg(peak_cfg),
    .sw_pos(sw_pos), .strobe(strobe), .carrier_up(carrier_up),
    .s1_pos(s1_pos), .s2_pos(s2_pos)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rnd_thr(input int d, input int p);
    return (2 * d * p + FULL) / (2 * FULL);
  endfunction

  // Behavioural model: phase runs 0 .. 2*peak-1 over one carrier period
  int ph, pk, pend, th, eff;
  bit e_up, e_str, e_pos, mdl_live = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; pk = RP; pend = HALF; th = rnd_thr(HALF, RP);
    end else begin
      eff = duty_vld ? int'(duty_in) : pend;
      if (duty_vld) pend = int'(duty_in);
      ph = ph + 1;
      if (ph >= 2 * pk) begin
        ph = 0;
        pk = (peak_cfg == 0) ? 1 : int'(peak_cfg);
      end
      if (ph == 0 || ph == pk) th = rnd_thr((eff > FULL) ? FULL : eff, pk);
    end
    e_up  = ph < pk;
    e_str = (ph == 0) || (ph == pk);
    if (e_up) e_pos = (ph >= th);
    else      e_pos = ((ph - pk) < th);
    mdl_live = 1'b1;
  end

  always @(negedge clk) begin
    if (mdl_live && !rst) begin
      chk(strobe == e_str, "R1 strobe", int'(strobe), int'(e_str));
      chk(carrier_up == e_up, "R2 carrier_up", int'(carrier_up), int'(e_up));
      chk(sw_pos == e_pos, e_up ? "R7 sw_pos rising" : "R6 sw_pos falling",
          int'(sw_pos), int'(e_pos));
      chk(s1_pos == !e_up && s2_pos == e_up, "R9 s1/s2", int'({s1_pos, s2_pos}),
          int'({!e_up, e_up}));
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_min();
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (strobe && carrier_up) return;
    end
  endtask

  task automatic set_duty(input int d);
    @(negedge clk);
    duty_in = (DW+1)'(d);
    duty_vld = 1'b1;
    @(negedge clk);
    duty_vld = 1'b0;
  endtask

  // Called at a bottom strobe; samples n clocks starting with the current one
  task automatic count_run(input int n, output int pos, output int trans);
    bit prev;
    pos = 0; trans = 0; prev = sw_pos;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      if (sw_pos) pos++;
      if (k > 0 && !strobe && sw_pos != prev) trans++;
      prev = sw_pos;
    end
  endtask

  logic [31:0] lcg = 32'h1234_5678;
  int pos_n, tr_n, gap;

  initial begin
    // R11: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(strobe && carrier_up, "R11 reset at bottom rising", int'({strobe, carrier_up}), 3);
    chk(!sw_pos, "R11 reset sw_pos", int'(sw_pos), 0);
    chk(!s1_pos && s2_pos, "R11 reset order", int'({s1_pos, s2_pos}), 1);
    rst = 1'b0;

    // R11: first period uses reset peak and half duty: 10 of 20 clocks at +1
    count_run(1, pos_n, tr_n);
    wait_min();
    count_run(2 * RP, pos_n, tr_n);
    chk(pos_n == RP, "R11 reset duty half", pos_n, RP);

    // Mixed stimulus: duty writes at arbitrary clocks, peak changes (R3, R4, R5)
    for (int k = 0; k < 1500; k++) begin
      @(negedge clk);
      lcg = lcg * 32'd1103515245 + 32'd12345;
      duty_vld = (lcg[18:16] == 3'd0);
      duty_in  = lcg[26:20];
      if (k % 97 == 0) peak_cfg = (lcg[29:28] == 2'd0) ? CW'(lcg[31:30]) : CW'(lcg[11:8] + 2);
    end
    duty_vld = 1'b0;

    // R3: peak taken at the bottom; spacing of strobes equals the peak
    peak_cfg = 8'd5;
    wait_min(); wait_min();
    gap = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); gap++;
      if (strobe) break;
    end
    chk(gap == 5, "R3 strobe spacing", gap, 5);
    peak_cfg = 8'd0;
    wait_min(); wait_min();
    @(negedge clk);
    chk(strobe, "R3 zero peak treated as one", int'(strobe), 1);

    // R8: duty 0, full, and above full (R4 clamp) give flat halves
    peak_cfg = 8'd6;
    set_duty(0); wait_min(); wait_min();
    count_run(12, pos_n, tr_n);
    chk(tr_n == 0, "R8 duty zero transitions", tr_n, 0);
    chk(pos_n == 6, "R8 duty zero rising all +1", pos_n, 6);
    set_duty(FULL); wait_min(); wait_min();
    count_run(12, pos_n, tr_n);
    chk(tr_n == 0, "R8 duty full transitions", tr_n, 0);
    set_duty(100); wait_min(); wait_min();
    count_run(12, pos_n, tr_n);
    chk(tr_n == 0 && pos_n == 6, "R4 over-full code clamped", pos_n, 6);

    // R4: rounding tie, peak 7 at half duty -> threshold 4 -> 3 clocks +1 rising
    peak_cfg = 8'd7;
    set_duty(HALF); wait_min(); wait_min();
    count_run(7, pos_n, tr_n);
    chk(pos_n == 3, "R4 tie rounds up", pos_n, 3);

    // R10: half duty on even peak gives zero average
    peak_cfg = 8'd8;
    wait_min(); wait_min();
    count_run(16, pos_n, tr_n);
    chk(pos_n == 8, "R10 half duty balance", pos_n, 8);

    // R5: duty written inside a rising half waits for the next turning point
    peak_cfg = 8'd10;
    wait_min(); wait_min();
    duty_in = '0; duty_vld = 1'b1;
    @(negedge clk);
    duty_vld = 1'b0;
    pos_n = int'(sw_pos);
    for (int k = 2; k < 10; k++) begin
      @(negedge clk);
      if (sw_pos) pos_n++;
    end
    chk(pos_n == 5, "R5 current half unchanged", pos_n, 5);
    pos_n = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (sw_pos) pos_n++;
    end
    chk(pos_n == 0, "R5 new duty in next half (R6 falling all -1)", pos_n, 0);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule